// File: doc/BRIEF.md
# GPIO Pin Interrupt and Wake Detector

This block watches a set of already-debounced GPIO input levels and turns configured transitions or levels into sticky interrupt and wake status bits, one pair per pin. Each pin has its own configuration: a trigger-type select (edge or level), a two-bit active mode, an interrupt enable, an unmask bit and three wake-enable bits, one for each of three low-power states. When the trigger condition for a pin holds while its interrupt enable is set, the interrupt status bit is latched. If any of that pin's wake enables is also set, the wake status bit is latched as well.

Software clears the status bits by writing ones to them. This is modelled as a write strobe with a pin index and two clear bits. A zero in a clear bit leaves the status unchanged. Each pin drives a registered pending line towards an interrupt summary block. The line is high when either status bit is set and the pin is unmasked. Masking gates only the pending line: detection and latching continue while a pin is masked.

Top module: `gpio_irq_detect_bank`

## Requirements
- R1: While reset is high and on the first sample after it, every irq_sts, wake_sts and pending bit is 0, whatever the inputs are.
- R2: In edge mode (cfg_trig_level bit = 0) with active mode 2'b00, a pin's irq_sts sets one clock after a 0-to-1 change of its level. It does not set on a 1-to-0 change or on a steady level.
- R3: In edge mode with active mode 2'b01, irq_sts sets one clock after a 1-to-0 change of the level and not on a 0-to-1 change.
- R4: In edge mode with active mode 2'b10, irq_sts sets on both 0-to-1 and 1-to-0 changes.
- R5: In level mode (cfg_trig_level bit = 1), active mode 2'b00 sets irq_sts on every clock the level is 1, and 2'b01 on every clock it is 0. A clear written while the active level is present leaves the bit set.
- R6: Level mode with active mode 2'b10 or 2'b11, and edge mode with 2'b11, never set a status bit.
- R7: A write with clr_we=1 clears the irq_sts bit of pin clr_idx when clr_irq=1, and its wake_sts bit when clr_wake=1. A clear bit of 0 leaves that status unchanged. Other pins are unaffected.
- R8: A status bit sets only while the pin's cfg_irq_en bit is 1. Clearing cfg_irq_en keeps any status already latched.
- R9: wake_sts of pin i sets on the same trigger as irq_sts when any of cfg_wake_en[3i+2:3i] is 1. With all three at 0 it stays 0.
- R10: pending[i] equals (irq_sts[i] | wake_sts[i]) & unmask, with unmask sampled at the clock that updated the status. Status still latches while the pin is masked (cfg_unmask bit = 0).
- R11: A level that is already 1 when reset is released is not taken as a 0-to-1 edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NPINS | Debounced pin levels |
| cfg_trig_level | input | NPINS | 1 = level trigger, 0 = edge trigger |
| cfg_act_mode | input | 2*NPINS | Active mode of pin i in bits [2i+1:2i]: 00 high/rising, 01 low/falling, 10 both edges, 11 none |
| cfg_irq_en | input | NPINS | Interrupt detection enable |
| cfg_unmask | input | NPINS | 1 = pending line allowed |
| cfg_wake_en | input | 3*NPINS | Wake enables of pin i in bits [3i+2:3i] |
| clr_we | input | 1 | Status write strobe |
| clr_idx | input | IDXW | Pin addressed by the write |
| clr_irq | input | 1 | Write-one-to-clear of irq_sts |
| clr_wake | input | 1 | Write-one-to-clear of wake_sts |
| irq_sts | output | NPINS | Sticky interrupt status |
| wake_sts | output | NPINS | Sticky wake status |
| pending | output | NPINS | Registered pending lines to the summary block |

## Verification
The assertions assume that the pin levels and all configuration inputs change only between clock edges and are stable at the sampling edge. They also assume that clr_idx is meaningful only while clr_we is high. The stimulus meets these assumptions by driving every input on the falling clock edge and raising clr_we for exactly one cycle, with the index already set. Status-drop checks count a fall as legal only after a matching clear write, so the bench makes no other change to the status bits outside reset.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    ACT_HIGH = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_BOTH = 2'b10,
    ACT_NONE = 2'b11
  } act_mode_e;

  localparam int unsigned WAKE_STATES = 3;
  localparam int unsigned MODE_W      = 2;
endpackage

// File: rtl/gpio_lvl_history.sv
module gpio_lvl_history #(
  parameter int unsigned NPINS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] prev_lvl,
  output logic             hist_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= '0;
      hist_vld <= 1'b0;
    end else begin
      prev_lvl <= lvl;
      hist_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/gpio_trig_eval.sv
module gpio_trig_eval
  import gpio_irq_pkg::*;
(
  input  logic       lvl,
  input  logic       prev_lvl,
  input  logic       hist_vld,
  input  logic       level_sel,
  input  act_mode_e  mode,
  output logic       trig
);
  logic rise;
  logic fall;

  assign rise = hist_vld & lvl & ~prev_lvl;
  assign fall = hist_vld & ~lvl & prev_lvl;

  always_comb begin
    trig = 1'b0;
    if (level_sel) begin
      unique case (mode)
        ACT_HIGH: trig = lvl;
        ACT_LOW:  trig = ~lvl;
        default:  trig = 1'b0;
      endcase
    end else begin
      unique case (mode)
        ACT_HIGH: trig = rise;
        ACT_LOW:  trig = fall;
        ACT_BOTH: trig = rise | fall;
        default:  trig = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sts_cell.sv
module gpio_sts_cell (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic wake_arm,
  input  logic clr_irq,
  input  logic clr_wake,
  input  logic unmask,
  output logic irq_sts,
  output logic wake_sts,
  output logic pending
);
  logic irq_nxt;
  logic wake_nxt;

  // a new trigger wins over a clear in the same cycle
  assign irq_nxt  = (irq_sts & ~clr_irq) | hit;
  assign wake_nxt = (wake_sts & ~clr_wake) | (hit & wake_arm);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_sts  <= 1'b0;
      wake_sts <= 1'b0;
      pending  <= 1'b0;
    end else begin
      irq_sts  <= irq_nxt;
      wake_sts <= wake_nxt;
      pending  <= (irq_nxt | wake_nxt) & unmask;
    end
  end
endmodule

// File: rtl/gpio_irq_detect_bank.sv
module gpio_irq_detect_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 4,
  parameter int unsigned IDXW  = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPINS-1:0]             pin_level,
  input  logic [NPINS-1:0]             cfg_trig_level,
  input  logic [MODE_W*NPINS-1:0]      cfg_act_mode,
  input  logic [NPINS-1:0]             cfg_irq_en,
  input  logic [NPINS-1:0]             cfg_unmask,
  input  logic [WAKE_STATES*NPINS-1:0] cfg_wake_en,
  input  logic                         clr_we,
  input  logic [IDXW-1:0]              clr_idx,
  input  logic                         clr_irq,
  input  logic                         clr_wake,
  output logic [NPINS-1:0]             irq_sts,
  output logic [NPINS-1:0]             wake_sts,
  output logic [NPINS-1:0]             pending
);
  logic [NPINS-1:0] prev_lvl;
  logic             hist_vld;
  logic [NPINS-1:0] clr_sel;

  gpio_lvl_history #(.NPINS(NPINS)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .lvl      (pin_level),
    .prev_lvl (prev_lvl),
    .hist_vld (hist_vld)
  );

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      clr_sel[i] = clr_we && (clr_idx == IDXW'(i));
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic trig;
    logic hit;
    logic wake_arm;

    gpio_trig_eval u_eval (
      .lvl       (pin_level[g]),
      .prev_lvl  (prev_lvl[g]),
      .hist_vld  (hist_vld),
      .level_sel (cfg_trig_level[g]),
      .mode      (act_mode_e'(cfg_act_mode[MODE_W*g +: MODE_W])),
      .trig      (trig)
    );

    assign hit      = trig & cfg_irq_en[g];
    assign wake_arm = |cfg_wake_en[WAKE_STATES*g +: WAKE_STATES];

    gpio_sts_cell u_sts (
      .clk      (clk),
      .rst      (rst),
      .hit      (hit),
      .wake_arm (wake_arm),
      .clr_irq  (clr_sel[g] & clr_irq),
      .clr_wake (clr_sel[g] & clr_wake),
      .unmask   (cfg_unmask[g]),
      .irq_sts  (irq_sts[g]),
      .wake_sts (wake_sts[g]),
      .pending  (pending[g])
    );
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int unsigned NPINS = 4,
  parameter int unsigned IDXW  = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NPINS-1:0]     cfg_trig_level,
  input logic [2*NPINS-1:0]   cfg_act_mode,
  input logic [NPINS-1:0]     cfg_irq_en,
  input logic [NPINS-1:0]     cfg_unmask,
  input logic [3*NPINS-1:0]   cfg_wake_en,
  input logic                 clr_we,
  input logic [IDXW-1:0]      clr_idx,
  input logic                 clr_irq,
  input logic                 clr_wake,
  input logic [NPINS-1:0]     irq_sts,
  input logic [NPINS-1:0]     wake_sts,
  input logic [NPINS-1:0]     pending
);
  logic [NPINS-1:0] c_irq;
  logic [NPINS-1:0] c_wake;
  logic [NPINS-1:0] wake_any;
  logic [NPINS-1:0] dead_cfg;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      c_irq[i]    = clr_we && clr_irq  && (clr_idx == IDXW'(i));
      c_wake[i]   = clr_we && clr_wake && (clr_idx == IDXW'(i));
      wake_any[i] = |cfg_wake_en[3*i +: 3];
      dead_cfg[i] = cfg_trig_level[i] ? cfg_act_mode[2*i+1]
                                      : (cfg_act_mode[2*i +: 2] == 2'b11);
    end
  end

  assert_rst_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (irq_sts == '0 && wake_sts == '0 && pending == '0));

  assert_irq_fall_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~irq_sts & $past(irq_sts) & ~$past(c_irq)) == '0));

  assert_wake_fall_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~wake_sts & $past(wake_sts) & ~$past(c_wake)) == '0));

  assert_en_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((irq_sts & ~$past(irq_sts) & ~$past(cfg_irq_en)) == '0));

  assert_dead_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((irq_sts & ~$past(irq_sts) & $past(dead_cfg)) == '0));

  assert_wake_arm_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((wake_sts & ~$past(wake_sts) &
                      ~($past(wake_any) & $past(cfg_irq_en))) == '0));

  assert_pend_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pending == ((irq_sts | wake_sts) & $past(cfg_unmask))));
endmodule

bind gpio_irq_detect_bank gpio_irq_detect_chk #(.NPINS(NPINS), .IDXW(IDXW)) u_chk (.*);

// File: tb/test_gpio_irq_detect_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_detect_bank;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] pin_level, cfg_trig_level, cfg_irq_en, cfg_unmask;
  logic [2*NP-1:0] cfg_act_mode;
  logic [3*NP-1:0] cfg_wake_en;
  logic          clr_we, clr_irq, clr_wake;
  logic [1:0]    clr_idx;
  logic [NP-1:0] irq_sts, wake_sts, pending;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  gpio_irq_detect_bank #(.NPINS(NP)) i_gpio_irq_detect_bank (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic defaults();
    pin_level = '0; cfg_trig_level = '0; cfg_act_mode = '0;
    cfg_irq_en = '0; cfg_unmask = '0; cfg_wake_en = '0;
    clr_we = 0; clr_irq = 0; clr_wake = 0; clr_idx = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    step(); step();
    rst = 0;
    step();
  endtask

  task automatic clear(int idx, bit ci, bit cw);
    clr_idx = 2'(idx); clr_irq = ci; clr_wake = cw; clr_we = 1;
    step();
    clr_we = 0; clr_irq = 0; clr_wake = 0;
  endtask

  task automatic t_reset();
    defaults();
    @(negedge clk);
    rst = 1;
    cfg_trig_level = '1; cfg_irq_en = '1; cfg_unmask = '1; cfg_wake_en = '1;
    pin_level = '1;
    step(); step();
    chk("R1 irq in reset", irq_sts, 0);
    chk("R1 wake in reset", wake_sts, 0);
    chk("R1 pending in reset", pending, 0);
    defaults();
    do_reset();
    chk("R1 irq after reset", irq_sts, 0);
  endtask

  task automatic t_rise();
    defaults(); do_reset();
    cfg_irq_en = 4'b0001;
    step();
    chk("R2 steady low", irq_sts, 0);
    pin_level[0] = 1; step();
    chk("R2 rising sets", irq_sts, 4'b0001);
    clear(0, 1, 0);
    chk("R2 steady high no set", irq_sts, 0);
    pin_level[0] = 0; step();
    chk("R2 falling ignored", irq_sts, 0);
  endtask

  task automatic t_fall();
    defaults(); do_reset();
    cfg_irq_en = 4'b0010; cfg_act_mode = 8'b0000_0100;
    pin_level[1] = 1; step();
    chk("R3 rising ignored", irq_sts, 0);
    pin_level[1] = 0; step();
    chk("R3 falling sets", irq_sts, 4'b0010);
  endtask

  task automatic t_both();
    defaults(); do_reset();
    cfg_irq_en = 4'b0100; cfg_act_mode = 8'b0010_0000;
    pin_level[2] = 1; step();
    chk("R4 rising sets", irq_sts, 4'b0100);
    clear(2, 1, 0);
    chk("R4 cleared", irq_sts, 0);
    pin_level[2] = 0; step();
    chk("R4 falling sets", irq_sts, 4'b0100);
  endtask

  task automatic t_level();
    defaults(); do_reset();
    cfg_irq_en = 4'b1000; cfg_trig_level = 4'b1000;
    pin_level[3] = 1; step();
    chk("R5 high level sets", irq_sts, 4'b1000);
    clear(3, 1, 0);
    chk("R5 reasserts over clear", irq_sts, 4'b1000);
    pin_level[3] = 0; step();
    clear(3, 1, 0);
    chk("R5 clears once inactive", irq_sts, 0);
    cfg_irq_en = 4'b0001; cfg_trig_level = 4'b0001; cfg_act_mode = 8'b0000_0001;
    step();
    chk("R5 low level sets", irq_sts, 4'b0001);
  endtask

  task automatic t_dead();
    defaults(); do_reset();
    cfg_irq_en = 4'b0111; cfg_trig_level = 4'b0011; cfg_act_mode = 8'b0011_1110;
    cfg_wake_en = '1;
    pin_level = 4'b0111; step();
    pin_level = 4'b0000; step(); step();
    chk("R6 unused modes irq", irq_sts, 0);
    chk("R6 unused modes wake", wake_sts, 0);
  endtask

  task automatic t_clear();
    defaults(); do_reset();
    cfg_irq_en = 4'b0011; cfg_wake_en = 12'b000_000_001_001;
    pin_level = 4'b0011; step();
    chk("R7 both set", irq_sts, 4'b0011);
    clear(0, 0, 0);
    chk("R7 zero write keeps", irq_sts, 4'b0011);
    clear(0, 1, 0);
    chk("R7 clears only pin0", irq_sts, 4'b0010);
    chk("R7 wake kept on irq clear", wake_sts, 4'b0011);
    clear(1, 0, 1);
    chk("R7 wake clear keeps irq", irq_sts, 4'b0010);
    chk("R7 wake clear pin1", wake_sts, 4'b0001);
  endtask

  task automatic t_enable();
    defaults(); do_reset();
    pin_level[0] = 1; step();
    chk("R8 disabled no set", irq_sts, 0);
    cfg_irq_en = 4'b0001;
    pin_level[0] = 0; step();
    pin_level[0] = 1; step();
    chk("R8 enabled sets", irq_sts, 4'b0001);
    cfg_irq_en = 0; step();
    chk("R8 status kept after disable", irq_sts, 4'b0001);
  endtask

  task automatic t_wake();
    defaults(); do_reset();
    cfg_irq_en = 4'b0111; cfg_wake_en = 12'b000_100_000_001;
    pin_level = 4'b0111; step();
    chk("R9 irq all three", irq_sts, 4'b0111);
    chk("R9 wake only armed pins", wake_sts, 4'b0101);
    clear(0, 0, 1);
    chk("R9 wake cleared pin0", wake_sts, 4'b0100);
    chk("R9 irq untouched", irq_sts, 4'b0111);
  endtask

  task automatic t_mask();
    defaults(); do_reset();
    cfg_irq_en = 4'b0001; cfg_wake_en = 12'b000_000_000_010;
    pin_level[0] = 1; step();
    chk("R10 latched while masked", irq_sts, 4'b0001);
    chk("R10 masked no pending", pending, 0);
    cfg_unmask = 4'b0001; step();
    chk("R10 unmask pending", pending, 4'b0001);
    clear(0, 1, 0);
    chk("R10 wake keeps pending", pending, 4'b0001);
    clear(0, 0, 1);
    chk("R10 pending drops with status", pending, 0);
  endtask

  task automatic t_hist();
    defaults();
    cfg_irq_en = 4'b0001; pin_level[0] = 1;
    @(negedge clk);
    rst = 1; step(); step();
    rst = 0; step(); step(); step();
    chk("R11 high at reset release", irq_sts, 0);
  endtask

  initial begin
    rst = 1;
    defaults();
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_dead();
    t_clear();
    t_enable();
    t_wake();
    t_mask();
    t_hist();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule